// File: doc/BRIEF.md
# Two-Bank Serial Port Expander Slave

This block is the serial-bus slave of a sixteen-line port expander. It answers two 7-bit addresses that share a 4-bit low field. The prefix `110` selects a bank of eight bidirectional open-drain I/O lines. The prefix `101` selects a bank of eight push-pull outputs. A write sets the whole 8-bit latch of the addressed bank with every data byte. A read returns the levels sampled on the pins at each acknowledge, not the latch contents. A read of the I/O bank alternates between pin levels and the transition flags supplied by the neighbouring change-detect logic.

The SCL and SDA inputs arrive already synchronised and oversampled by the system clock. The slave drives SDA only through a pull-down enable. Three one-cycle strobes tell the transition logic when an address was acknowledged, when a data byte was acknowledged, and when a STOP ended an active transfer. A bank indicator names the bank of the current transfer. A power-on reset sets the latches to parameter defaults. A separate bus-abort input returns only the serial engine to idle.

The controller is a state machine with these states: `ST_IDLE` (bus free), `ST_ADDR` (address byte being shifted in), `ST_ADDR_ACK` (address acknowledge), `ST_WR_DATA` / `ST_WR_ACK` (write byte, then slave acknowledge), `ST_RD_DATA` / `ST_RD_ACK` (read byte, then master acknowledge) and `ST_HOLD` (not addressed or NACKed, ignore the bus).

The transitions are:
- START from any state goes to `ST_ADDR`.
- STOP from any state goes to `ST_IDLE`.
- At the eighth falling SCL edge, `ST_ADDR` goes to `ST_ADDR_ACK` on a hit and to `ST_HOLD` otherwise.
- `ST_ADDR_ACK` goes to `ST_RD_DATA` or `ST_WR_DATA` at the falling edge that ends it, depending on R/W.
- The data states go to their acknowledge state after eight bits, and back at the falling edge that ends the acknowledge.
- `ST_RD_ACK` goes to `ST_HOLD` when SDA is high at the ninth rising edge.
- A bus abort forces `ST_IDLE`.

Top module: `pexp_i2c_slave`

## Requirements
- R1: While `rst_n` is low, `pp_latch_o` holds `PP_DEFAULT` (default 8'h0F), `io_latch_o` holds `IO_DEFAULT` (default 8'hFF), `sda_pull_o` is 0 and all strobes are 0.
- R2: The address byte is sent MSB first as {A6..A0, R/W}. It is acknowledged (SDA pulled low during the ninth clock) only when A6..A4 is 3'b110 (I/O bank) or 3'b101 (push-pull bank) and A3..A0 equals `addr_lo_i`. Any other address gets no acknowledge, and the data bytes that follow it change no latch and are not acknowledged.
- R3: After a write address (R/W = 0), each data byte is shifted in MSB first, acknowledged, and written whole into the addressed bank's latch at the rising SCL edge of its acknowledge. Any number of bytes may follow, until STOP or START.
- R4: After a read address (R/W = 1) to the push-pull bank, every byte returns `pp_pins_i` as sampled at the rising SCL edge of the preceding acknowledge (the address acknowledge or the master's acknowledge), MSB first.
- R5: A read of the I/O bank returns `io_pins_i`, then `io_flags_i`, then pins, then flags, and so on. Each value is sampled at the rising SCL edge of the preceding acknowledge.
- R6: When the master leaves SDA high on the ninth clock of a read byte (NACK), the slave releases SDA and drives nothing on later clocks until START or STOP.
- R7: A repeated START re-enters address reception from any state and raises no STOP strobe.
- R8: `stop_stb_o` pulses for one cycle on a STOP that ends a transfer begun with START. A STOP on an idle bus raises no strobe.
- R9: `addr_ack_stb_o` pulses once per acknowledged address, and `data_ack_stb_o` once per acknowledged data byte (slave acknowledge on write, master acknowledge on read). `io_sel_o` is 1 when the current bank is the I/O bank. At most one strobe is high in any cycle.
- R10: Holding `bus_rst_n` low returns the engine to idle and releases SDA. The rest of an interrupted byte is ignored (no acknowledge, no latch change), latch contents are kept, and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low power-on reset of engine and latches |
| bus_rst_n | input | 1 | Active-low abort of the serial engine only |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level |
| sda_pull_o | output | 1 | 1 enables the SDA pull-down |
| addr_lo_i | input | 4 | Shared low address bits A3..A0 |
| pp_pins_i | input | 8 | Sampled push-pull pin levels |
| io_pins_i | input | 8 | Sampled open-drain I/O pin levels |
| io_flags_i | input | 8 | Transition flags from change-detect logic |
| pp_latch_o | output | 8 | Push-pull bank output latch |
| io_latch_o | output | 8 | I/O bank output latch |
| io_sel_o | output | 1 | Current transfer targets the I/O bank |
| addr_ack_stb_o | output | 1 | One-cycle pulse at address acknowledge |
| data_ack_stb_o | output | 1 | One-cycle pulse at data acknowledge |
| stop_stb_o | output | 1 | One-cycle pulse at STOP ending a transfer |

## Verification
All 128 address bytes with write direction are swept for two values of the low address field. This separates acceptance on prefix from acceptance on the low field, and shows that a rejected address leaves both latches alone. Reads change the pin inputs right after every acknowledge. A byte that carries the newer value therefore shows sampling at the wrong edge, and I/O reads of four bytes separate the pin/flag alternation from a fixed source. Multi-byte writes, master NACK followed by extra clocks, a repeated START between banks and a bus abort in mid-byte each test one exit from the byte loop. Strobe counters show which exits raise a STOP strobe.

// File: rtl/pexp_pkg.sv
package pexp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_HOLD
    } pexp_state_e;

    localparam int          ADDR_PFX_W = 3;
    localparam logic [2:0]  PFX_IO     = 3'b110;
    localparam logic [2:0]  PFX_PP     = 3'b101;

endpackage

// File: rtl/pexp_bus_cond.sv
module pexp_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/pexp_shifter.sv
module pexp_shifter #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          cnt_inc_i,
    input  logic          rx_shift_i,
    input  logic          tx_shift_i,
    input  logic          load_i,
    input  logic [W-1:0]  load_val_i,
    input  logic          sda_i,
    output logic [W-1:0]  data_o,
    output logic [CW-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
        end else if (load_i) begin
            data_o <= load_val_i;
        end else if (rx_shift_i) begin
            data_o <= {data_o[W-2:0], sda_i};
        end else if (tx_shift_i) begin
            data_o <= {data_o[W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (cnt_inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/pexp_bank_regs.sv
module pexp_bank_regs #(
    parameter int              W       = 8,
    parameter int              NB      = 2,
    parameter int              SW      = 1,
    parameter logic [NB*W-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [SW-1:0]   wr_sel_i,
    input  logic [W-1:0]    wr_data_i,
    output logic [NB*W-1:0] q_o
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o[b*W +: W] <= RST_VAL[b*W +: W];
            end else if (wr_en_i && (wr_sel_i == SW'(b))) begin
                q_o[b*W +: W] <= wr_data_i;
            end
        end
    end

endmodule

// File: rtl/pexp_i2c_slave.sv
module pexp_i2c_slave
    import pexp_pkg::*;
#(
    parameter int               BYTE_W     = 8,
    parameter logic [BYTE_W-1:0] PP_DEFAULT = 8'h0F,
    parameter logic [BYTE_W-1:0] IO_DEFAULT = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [3:0]        addr_lo_i,
    input  logic [BYTE_W-1:0] pp_pins_i,
    input  logic [BYTE_W-1:0] io_pins_i,
    input  logic [BYTE_W-1:0] io_flags_i,
    output logic [BYTE_W-1:0] pp_latch_o,
    output logic [BYTE_W-1:0] io_latch_o,
    output logic              io_sel_o,
    output logic              addr_ack_stb_o,
    output logic              data_ack_stb_o,
    output logic              stop_stb_o
);
    localparam int              CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam int              NBANK    = 2;
    localparam int              SEL_W    = 1;

    pexp_state_e st, nxt;

    logic scl_rise, scl_fall, start_c, stop_c;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              rw_q, io_q, flag_ph;
    logic [NBANK*BYTE_W-1:0] banks;

    pexp_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_c),
        .stop_o    (stop_c)
    );

    logic byte_done, hit_io, hit_pp, in_ack;
    logic clr_c, cnt_inc_c, rx_c, tx_c, load_c, wr_c;
    logic [BYTE_W-1:0] rd_val;

    always_comb begin
        byte_done = (cnt == CNT_FULL);
        hit_io = (sh[BYTE_W-1 -: ADDR_PFX_W] == PFX_IO) && (sh[4:1] == addr_lo_i);
        hit_pp = (sh[BYTE_W-1 -: ADDR_PFX_W] == PFX_PP) && (sh[4:1] == addr_lo_i);
        in_ack = (st == ST_ADDR_ACK) || (st == ST_WR_ACK) || (st == ST_RD_ACK);
        clr_c     = start_c || !bus_rst_n || (scl_fall && in_ack);
        cnt_inc_c = scl_rise && ((st == ST_ADDR) || (st == ST_WR_DATA) || (st == ST_RD_DATA));
        rx_c      = scl_rise && ((st == ST_ADDR) || (st == ST_WR_DATA));
        tx_c      = scl_fall && (st == ST_RD_DATA) && !byte_done;
        load_c    = scl_rise && (((st == ST_ADDR_ACK) && rw_q) ||
                                 ((st == ST_RD_ACK) && !sda_i));
        wr_c      = scl_rise && (st == ST_WR_ACK) && bus_rst_n;
        if (io_q && (st == ST_RD_ACK) && flag_ph) rd_val = io_flags_i;
        else if (io_q)                            rd_val = io_pins_i;
        else                                      rd_val = pp_pins_i;
    end

    pexp_shifter #(.W(BYTE_W), .CW(CNT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_c),
        .cnt_inc_i (cnt_inc_c),
        .rx_shift_i(rx_c),
        .tx_shift_i(tx_c),
        .load_i    (load_c),
        .load_val_i(rd_val),
        .sda_i     (sda_i),
        .data_o    (sh),
        .cnt_o     (cnt)
    );

    pexp_bank_regs #(
        .W      (BYTE_W),
        .NB     (NBANK),
        .SW     (SEL_W),
        .RST_VAL({IO_DEFAULT, PP_DEFAULT})
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_c),
        .wr_sel_i (io_q),
        .wr_data_i(sh),
        .q_o      (banks)
    );

    assign pp_latch_o = banks[0 +: BYTE_W];
    assign io_latch_o = banks[BYTE_W +: BYTE_W];
    assign io_sel_o   = io_q;

    // next-state logic
    always_comb begin
        nxt = st;
        if (start_c) begin
            nxt = ST_ADDR;
        end else if (stop_c) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE, ST_HOLD: nxt = st;
                ST_ADDR:
                    if (scl_fall && byte_done)
                        nxt = (hit_io || hit_pp) ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK:
                    if (scl_fall) nxt = rw_q ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:
                    if (scl_fall && byte_done) nxt = ST_WR_ACK;
                ST_WR_ACK:
                    if (scl_fall) nxt = ST_WR_DATA;
                ST_RD_DATA:
                    if (scl_fall && byte_done) nxt = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_rise && sda_i) nxt = ST_HOLD;
                    else if (scl_fall)     nxt = ST_RD_DATA;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          st <= ST_IDLE;
        else if (!bus_rst_n) st <= ST_IDLE;
        else                 st <= nxt;
    end

    // transfer context and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q           <= 1'b0;
            io_q           <= 1'b0;
            flag_ph        <= 1'b0;
            addr_ack_stb_o <= 1'b0;
            data_ack_stb_o <= 1'b0;
            stop_stb_o     <= 1'b0;
        end else begin
            if ((st == ST_ADDR) && scl_fall && byte_done && !start_c && !stop_c) begin
                rw_q <= sh[0];
                io_q <= hit_io;
            end
            if (load_c) flag_ph <= (st == ST_RD_ACK) ? ~flag_ph : 1'b1;
            addr_ack_stb_o <= bus_rst_n && scl_rise && (st == ST_ADDR_ACK);
            data_ack_stb_o <= bus_rst_n && scl_rise &&
                              ((st == ST_WR_ACK) || ((st == ST_RD_ACK) && !sda_i));
            stop_stb_o     <= bus_rst_n && stop_c && (st != ST_IDLE);
        end
    end

    // output decode
    always_comb begin
        unique case (st)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull_o = 1'b1;
            ST_RD_DATA:             sda_pull_o = ~sh[BYTE_W-1];
            default:                sda_pull_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pexp_i2c_slave_chk.sv
module pexp_i2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rst_n,
    input logic       sda_pull_o,
    input logic [7:0] pp_latch_o,
    input logic [7:0] io_latch_o,
    input logic       io_sel_o,
    input logic       addr_ack_stb_o,
    input logic       data_ack_stb_o,
    input logic       stop_stb_o
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !sda_pull_o && !stop_stb_o && !addr_ack_stb_o && !data_ack_stb_o); // R1

    AST_ADDR_ACK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_stb_o |-> sda_pull_o); // R2

    AST_PP_WRITE_ONLY_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pp_latch_o) |-> data_ack_stb_o && !io_sel_o); // R3

    AST_IO_WRITE_ONLY_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(io_latch_o) |-> data_ack_stb_o && io_sel_o); // R3

    AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb_o |=> !stop_stb_o); // R8

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_ack_stb_o, data_ack_stb_o, stop_stb_o})); // R9

    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |=> !sda_pull_o); // R10

endmodule

bind pexp_i2c_slave pexp_i2c_slave_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_rst_n     (bus_rst_n),
    .sda_pull_o    (sda_pull_o),
    .pp_latch_o    (pp_latch_o),
    .io_latch_o    (io_latch_o),
    .io_sel_o      (io_sel_o),
    .addr_ack_stb_o(addr_ack_stb_o),
    .data_ack_stb_o(data_ack_stb_o),
    .stop_stb_o    (stop_stb_o)
);

// File: tb/tb_pexp_i2c_slave.sv
`timescale 1ns/1ps
module tb_pexp_i2c_slave;
    localparam int Q = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rst_n = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic [3:0] addr_lo = 4'hA;
    logic [7:0] pp_pins = 8'h00, io_pins = 8'h00, io_flags = 8'h00;
    logic [7:0] pp_latch, io_latch;
    logic io_sel, a_stb, d_stb, p_stb;

    int checks = 0, errors = 0;
    int n_addr = 0, n_data = 0, n_stop = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    pexp_i2c_slave dut (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
        .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
        .addr_lo_i(addr_lo), .pp_pins_i(pp_pins), .io_pins_i(io_pins),
        .io_flags_i(io_flags), .pp_latch_o(pp_latch), .io_latch_o(io_latch),
        .io_sel_o(io_sel), .addr_ack_stb_o(a_stb), .data_ack_stb_o(d_stb),
        .stop_stb_o(p_stb)
    );

    always @(posedge clk) begin
        if (a_stb) n_addr <= n_addr + 1;
        if (d_stb) n_data <= n_data + 1;
        if (p_stb) n_stop <= n_stop + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic r);
        sda_m = b; wq();
        scl = 1'b1; wq();
        r = sda_line; wq();
        scl = 1'b0; wq();
    endtask

    task automatic do_start();
        sda_m = 1'b1; wq();
        scl = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl = 1'b0; wq();
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wq();
        scl = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(d[i], r);
        bit_io(1'b1, r);
        acked = !r;
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, r);
            d[i] = r;
        end
        bit_io(!mack, r);
    endtask

    function automatic logic hit(input logic [6:0] a, input logic [3:0] lo);
        return ((a[6:4] == 3'b110) || (a[6:4] == 3'b101)) && (a[3:0] == lo);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        logic [7:0] m_pp, m_io;
        int s0;
        m_pp = 8'h0F; m_io = 8'hFF;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 pp_latch", pp_latch, 8'h0F);
        chk("R1 io_latch", io_latch, 8'hFF);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 strobes", {a_stb, d_stb, p_stb}, 0);
        rst_n = 1'b1; wq();

        // R2/R3 address sweep over all write addresses, two low-field values
        for (int pass = 0; pass < 2; pass++) begin
            addr_lo = pass ? 4'h5 : 4'hA;
            for (int a = 0; a < 128; a++) begin
                logic [7:0] dv;
                dv = 8'(a) ^ 8'h5A;
                do_start();
                wr_byte({7'(a), 1'b0}, ack);
                chk("R2 address ack", ack, hit(7'(a), addr_lo));
                wr_byte(dv, ack);
                chk("R2/R3 data ack", ack, hit(7'(a), addr_lo));
                if (hit(7'(a), addr_lo)) begin
                    if (a[6:4] == 3'b110) m_io = dv; else m_pp = dv;
                end
                do_stop();
                wq();
                chk("R2/R3 pp latch", pp_latch, m_pp);
                chk("R2/R3 io latch", io_latch, m_io);
            end
        end
        addr_lo = 4'hA;

        // R3 multi-byte write, R9 strobe counts
        s0 = n_data;
        do_start();
        wr_byte({3'b101, 4'hA, 1'b0}, ack);
        chk("R9 io_sel pp", io_sel, 0);
        wr_byte(8'hC3, ack); chk("R3 byte1 ack", ack, 1); chk("R3 byte1", pp_latch, 8'hC3);
        wr_byte(8'h81, ack); chk("R3 byte2", pp_latch, 8'h81);
        wr_byte(8'h7E, ack); chk("R3 byte3", pp_latch, 8'h7E);
        chk("R3 io untouched", io_latch, m_io);
        s0 = n_data - s0;
        chk("R9 data strobes", s0, 3);
        do_stop();
        m_pp = 8'h7E;

        // R4 push-pull read with resample at each acknowledge
        pp_pins = 8'hA5;
        do_start();
        wr_byte({3'b101, 4'hA, 1'b1}, ack);
        chk("R4 addr ack", ack, 1);
        pp_pins = 8'h3C;
        rd_byte(1'b1, d); chk("R4 byte1", d, 8'hA5);
        pp_pins = 8'hE1;
        rd_byte(1'b1, d); chk("R4 byte2", d, 8'h3C);
        pp_pins = 8'h00;
        rd_byte(1'b0, d); chk("R4 byte3", d, 8'hE1);
        chk("R4 latch kept", pp_latch, m_pp);
        do_stop();

        // R5 I/O read alternation, R6 NACK then extra clocks
        s0 = n_addr;
        io_pins = 8'h96; io_flags = 8'h21;
        do_start();
        wr_byte({3'b110, 4'hA, 1'b1}, ack);
        chk("R9 io_sel io", io_sel, 1);
        chk("R9 addr strobe", n_addr - s0, 1);
        io_pins = 8'h4B; io_flags = 8'h18;
        rd_byte(1'b1, d); chk("R5 pins1", d, 8'h96);
        rd_byte(1'b1, d); chk("R5 flags1", d, 8'h18);
        io_pins = 8'hD2; io_flags = 8'h81;
        rd_byte(1'b1, d); chk("R5 pins2", d, 8'h4B);
        rd_byte(1'b0, d); chk("R5 flags2", d, 8'h81);
        io_pins = 8'h00;
        rd_byte(1'b0, d); chk("R6 released after NACK", d, 8'hFF);
        chk("R6 sda_pull", sda_pull, 0);
        s0 = n_stop;
        do_stop();
        wq();
        chk("R8 stop strobe", n_stop - s0, 1);

        // R7 repeated start between banks
        s0 = n_stop;
        io_pins = 8'h5C;
        do_start();
        wr_byte({3'b101, 4'hA, 1'b0}, ack);
        wr_byte(8'h33, ack);
        do_start();
        chk("R7 no stop strobe", n_stop - s0, 0);
        wr_byte({3'b110, 4'hA, 1'b1}, ack);
        chk("R7 readdress ack", ack, 1);
        rd_byte(1'b0, d); chk("R7 read after restart", d, 8'h5C);
        do_stop();
        m_pp = 8'h33;
        chk("R7 first write", pp_latch, m_pp);

        // R10 abort mid-byte
        s0 = n_stop;
        do_start();
        wr_byte({3'b110, 4'hA, 1'b0}, ack);
        for (int i = 0; i < 4; i++) bit_io(1'b0, ack);
        bus_rst_n = 1'b0; wq(); bus_rst_n = 1'b1; wq();
        chk("R10 sda released", sda_pull, 0);
        for (int i = 0; i < 4; i++) bit_io(1'b0, ack);
        bit_io(1'b1, ack);
        chk("R10 no ack", ack, 1);
        chk("R10 io latch kept", io_latch, m_io);
        chk("R10 pp latch kept", pp_latch, m_pp);
        do_stop();
        wq();
        chk("R8/R10 no stop strobe", n_stop - s0, 0);
        do_start();
        wr_byte({3'b110, 4'hA, 1'b0}, ack);
        wr_byte(8'h0C, ack);
        do_stop();
        chk("R10 works after abort", io_latch, 8'h0C);

        // R1 reset again
        rst_n = 1'b0; wq();
        chk("R1 pp default", pp_latch, 8'h0F);
        chk("R1 io default", io_latch, 8'hFF);
        rst_n = 1'b1; wq();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule